// File: doc/BRIEF.md
# Sampled PI Current Regulator

This block closes the current loop of a single-phase grid-tied inverter. It runs once per modulation period. A one-cycle sample strobe, aligned with the carrier, captures a grid-voltage sample and a sensed inverter-current sample. The sensor gain is 1 V/A, so the current code is the current itself.

The current reference is the grid-voltage sample multiplied by a reference gain. It is therefore in phase with the grid, and only active power is injected. The block subtracts the sensed current from the reference. A proportional-plus-integral law acts on that error. The result is saturated to the carrier amplitude and handed to the PWM comparator as the modulating value.

The work is spread over a short fixed pipeline. A result appears a known number of clocks after the strobe, well inside the calculation budget of one modulation period. All gains are signed fixed-point numbers with `FRAC` fraction bits, so a gain code of 2^FRAC means 1.0. The integrator is held inside the output limits, so it cannot wind up.

Top module: `pi_current_reg`

## Requirements
- R1: On a strobe, the reference is the grid sample times the reference gain, arithmetically shifted right by FRAC bits (rounding toward minus infinity). The grid sample, the current sample and all three gains are captured on the strobe edge.
- R2: The error is the reference minus the sensed current. The proportional term is the error times the proportional gain, arithmetically shifted right by FRAC bits.
- R3: On each strobe, the integrator adds the error times the integral gain, arithmetically shifted right by FRAC bits. The sum is clamped to the range -OUT_MAX to +OUT_MAX, so a later error of opposite sign takes effect at once.
- R4: The output is the sum of the proportional term and the updated integrator, saturated to the range -OUT_MAX to +OUT_MAX.
- R5: valid_o is a one-cycle pulse. It is sampled high on the fourth rising edge after the edge that saw strobe_i high, and u_o carries the new value from that same cycle.
- R6: Without a strobe, u_o keeps its last value whatever the sample and gain inputs do.
- R7: Reset drives u_o to 0 and valid_o low, and clears the integrator to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | One-cycle sample strobe, once per modulation period |
| vgrid_i | input | DW | Signed grid-voltage sample |
| isense_i | input | DW | Signed sensed inverter current |
| kref_i | input | GW | Signed reference gain, FRAC fraction bits |
| kp_i | input | GW | Signed proportional gain, FRAC fraction bits |
| ki_i | input | GW | Signed integral gain, FRAC fraction bits |
| u_o | output | OW | Signed saturated modulating value |
| valid_o | output | 1 | One-cycle pulse when u_o is updated |

## Verification
The bench drives a sequence of periods with a large error that pushes the integrator into its clamp, then an error of opposite sign. A design that lets the integrator wind up would keep the output stuck at the limit instead of leaving it at once. Small negative products check that the shifts round toward minus infinity; a design that truncates toward zero gives outputs one count too high. The bench also samples valid_o in the cycles on both sides of the expected pulse, which exposes a pipeline with a stage too many or too few. It then checks, after reset, that no integrator state from earlier periods survives.

// File: rtl/pi_current_reg.sv
module pi_current_reg #(
  parameter int DW = 12,
  parameter int GW = 16,
  parameter int FRAC = 8,
  parameter int OW = 8,
  parameter int OUT_MAX = 27
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe_i,
  input  logic signed [DW-1:0] vgrid_i,
  input  logic signed [DW-1:0] isense_i,
  input  logic signed [GW-1:0] kref_i,
  input  logic signed [GW-1:0] kp_i,
  input  logic signed [GW-1:0] ki_i,
  output logic signed [OW-1:0] u_o,
  output logic                 valid_o
);
  localparam int RW  = DW + GW;
  localparam int EW  = RW + 1;
  localparam int PW  = EW + GW;
  localparam int SW  = PW + 1;
  localparam int IW  = OW + 2;
  localparam int LAT = 4;

  logic signed [RW-1:0] ref_prod, ref_r;
  logic signed [DW-1:0] i_r;
  logic signed [GW-1:0] kp_r, ki_r;
  logic signed [EW-1:0] err_r;
  logic signed [PW-1:0] p_prod, i_prod, p_r;
  logic signed [IW-1:0] integ_r;
  logic signed [SW-1:0] integ_sum, out_sum;
  logic                 st1, st2, st3;

  function automatic logic signed [OW-1:0] sat(input logic signed [SW-1:0] x);
    if (x > SW'(OUT_MAX))       return OW'(OUT_MAX);
    else if (x < -SW'(OUT_MAX)) return OW'(-OUT_MAX);
    else                        return OW'(x);
  endfunction

  assign ref_prod  = RW'(vgrid_i) * RW'(kref_i);
  assign p_prod    = PW'(err_r) * PW'(kp_r);
  assign i_prod    = PW'(err_r) * PW'(ki_r);
  assign integ_sum = SW'(integ_r) + SW'(i_prod >>> FRAC);
  assign out_sum   = SW'(p_r) + SW'(integ_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_r <= '0; i_r <= '0; kp_r <= '0; ki_r <= '0;
      err_r <= '0; p_r <= '0; integ_r <= '0; u_o <= '0;
      st1 <= 1'b0; st2 <= 1'b0; st3 <= 1'b0; valid_o <= 1'b0;
    end else begin
      st1 <= strobe_i;
      st2 <= st1;
      st3 <= st2;
      valid_o <= st3;
      if (strobe_i) begin
        ref_r <= ref_prod >>> FRAC;
        i_r   <= isense_i;
        kp_r  <= kp_i;
        ki_r  <= ki_i;
      end
      if (st1) err_r <= EW'(ref_r) - EW'(i_r);
      if (st2) begin
        p_r     <= p_prod >>> FRAC;
        integ_r <= IW'(sat(integ_sum));
      end
      if (st3) u_o <= sat(out_sum);
    end
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |-> ##LAT valid_o);
  assert_valid_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(strobe_i, LAT));
  assert_out_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (u_o <= OW'(OUT_MAX)) && (u_o >= OW'(-OUT_MAX)));
  assert_integ_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_r <= IW'(OUT_MAX)) && (integ_r >= IW'(-OUT_MAX)));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(u_o) |-> valid_o);
endmodule

// File: tb/pi_current_reg_bench.sv
module pi_current_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OUT_MAX = 27;
  localparam int NV = 9;
  // vgrid, isense, kref, kp, ki
  localparam int VEC [0:NV-1][0:4] = '{
    '{ 100,   90, 256, 256,  64},
    '{-200, -180, 128, 256,  64},
    '{  50,   60, 256, 128,  32},
    '{1000,    0, 256, 256, 256},
    '{1000,    0, 256,   0, 256},
    '{   0,   10, 256,   0, 256},
    '{  -1,    0, 256,   0,   1},
    '{ 300, -300, 256,   0,   0},
    '{   0, 2000, 256, 256,   0}
  };

  logic clk = 0, rst_n = 0, strobe = 0;
  logic signed [11:0] vg = 0, is = 0;
  logic signed [15:0] kref = 0, kp = 0, ki = 0;
  logic signed [7:0] u;
  logic valid;
  int checks = 0, fails = 0;
  longint integ = 0, expu = 0;
  bit done = 0;

  pi_current_reg u_pi_current_reg (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .vgrid_i(vg), .isense_i(is),
    .kref_i(kref), .kp_i(kp), .ki_i(ki), .u_o(u), .valid_o(valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint clampv(longint x);
    if (x > OUT_MAX) return OUT_MAX;
    if (x < -OUT_MAX) return -OUT_MAX;
    return x;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic period(int a, int b, int c, int d, int e);
    longint r, er, pt;
    vg = 12'(a); is = 12'(b); kref = 16'(c); kp = 16'(d); ki = 16'(e);
    r = (longint'(a) * c) >>> 8;
    er = r - b;
    pt = (er * d) >>> 8;
    integ = clampv(integ + ((er * e) >>> 8));
    expu = clampv(pt + integ);
    @(negedge clk) strobe = 1;
    @(negedge clk) strobe = 0;
    vg = 12'(-a); is = 12'(a); kp = 16'(e); ki = 16'(d);
    @(negedge clk) check("R5 valid low early", valid, 0);
    @(negedge clk) check("R5 valid low early", valid, 0);
    @(negedge clk) check("R5 valid pulse", valid, 1);
    check("R1 R2 R3 R4 output", u, expu);
    @(negedge clk) check("R5 valid one cycle", valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset output", u, 0);
    check("R7 reset valid", valid, 0);
    rst_n = 1;
    for (int k = 0; k < NV; k++)
      period(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], VEC[k][4]);
    // R6: no strobe, inputs move, output held
    for (int k = 0; k < 10; k++) begin
      @(negedge clk) vg = 12'(k * 37); is = 12'(-k * 11); kp = 16'(k * 50); ki = 16'(k * 9);
      check("R6 hold", u, expu);
      check("R6 no valid", valid, 0);
    end
    // drive integrator to clamp, then reset and confirm it is cleared (R7)
    period(1000, 0, 256, 0, 256);
    @(negedge clk) rst_n = 0;
    @(negedge clk) check("R7 reset output", u, 0);
    rst_n = 1;
    integ = 0;
    period(20, 0, 256, 0, 256);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule